// File: doc/BRIEF.md
# Link Event ID Check and Half-Word Packing Engine

This engine takes the stream of 16-bit packets that one event produces across a group of front-end links, each packet tagged with the link it came from. For every link it works out which level-1 event number to expect. That number is the event's own number, one more than it, or one less than it, as chosen by a 2-bit per-link resynchronisation code. It compares the event-number nibble and the 8-bit bunch-crossing number in each link header against the expected values. From the content of every packet it also collects a 10-bit error vector per link.

When the event ends, each link's error vector is ANDed with that link's error mask. Every link with a nonzero result steps its own counter and the global counter, and adds its masked bits to the event's error summary. In the meantime the engine removes link trailers that carry no useful flags, and removes link headers that stand in front of such a trailer with nothing between them. It packs the half-words that remain into 32-bit words with no gaps and reports how many words the event produced.

The expected event number, the bunch-crossing number, the resynchronisation codes and the error masks are driven on ports. They are held stable for the whole event.

Top module: `evid_pack_engine`

## Requirements
- R1: The expected event-number nibble of link k is bits 3:0 of evt_l1id plus an adjustment that depends on dyn_mask[2k+1:2k]: 00 and 11 add nothing, 01 adds 1 and 10 subtracts 1 (modulo 2^L1W). A link header whose bits 11:8 differ from this nibble sets error bit 5.
- R2: A link header whose bits 7:0 differ from evt_bcid sets error bit 6, but only while bcid_chk_en is 1. Packets that are not headers never set bit 5 or bit 6.
- R3: pkt_data[15:13] gives the packet type: 001 header, 010 trailer, 000 flagged error, 011 raw, and 1xx hit. The error bits are: 0 for a header with bit 12 set; 1 for a trailer with bit 12 set; 2 for any flagged-error packet; 3 for any raw packet (loss of sync); 4 for a hit tagged pkt_cond with bit 2 or bit 3 set; 7 for any packet with pkt_tmo; 8 for a trailer with bit 11 set; 9 for a trailer with bit 10 set.
- R4: One cycle after the cycle that follows pkt_last, each link's accumulated error vector is ANDed with err_mask[10k+9:10k]. Each nonzero result adds 1 to that link's counter, the global counter grows by the number of such links, and evt_err_summary is the OR of all the masked vectors.
- R5: A trailer is written to the output only when its bit 12 or its bit 11 is set.
- R6: A header is held back until the next packet arrives. It is removed when it has no error bits and that next packet is a trailer of the same link with bits 12, 11 and 10 clear and no pkt_tmo. A header that arrives with pkt_last is written out at once.
- R7: Surviving half-words are packed in arrival order, the earlier one in bits 15:0, with no gaps. At most one word leaves per cycle, and it is registered one cycle after the packet that completes it.
- R8: If an event leaves an odd half-word over, the cycle after pkt_last emits it in bits 15:0 with bits 31:16 zero.
- R9: evt_done pulses for one cycle, two cycles after pkt_last is accepted. evt_word_count then shows the number of words that event produced.
- R10: After reset there is no output word and no evt_done, and every error counter and the summary are zero.
- R11: The source leaves pkt_valid low for at least one cycle after a packet with pkt_last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bcid_chk_en | input | 1 | Enables the bunch-crossing comparison |
| evt_l1id | input | L1W | Event number of the current event |
| evt_bcid | input | 8 | Bunch-crossing number of the current event |
| dyn_mask | input | 2*NLINK | Per-link resynchronisation code |
| err_mask | input | 10*NLINK | Per-link error mask |
| pkt_valid | input | 1 | Packet present this cycle |
| pkt_last | input | 1 | Last packet of the event |
| pkt_link | input | LINKW | Source link of the packet |
| pkt_cond | input | 1 | Hit packet is in condensed format |
| pkt_tmo | input | 1 | Packet carries a readout timeout |
| pkt_data | input | 16 | Packet half-word |
| out_valid | output | 1 | Output word valid |
| out_word | output | 32 | Packed output word |
| evt_done | output | 1 | End-of-event pulse |
| evt_word_count | output | WCW | Words produced by the finished event |
| evt_err_summary | output | 10 | Masked error summary of the finished event |
| link_err_count | output | CNTW*NLINK | Per-link error counters, link k at bits k*CNTW |
| global_err_count | output | GCNTW | Global error counter |

## Verification
The bound checker watches the end-of-event timing and the single-cycle evt_done pulse on every cycle. It also checks that the counters and the summary move only on that pulse, that a zero summary leaves the global count alone, that no word appears without a packet or a flush behind it, and that the source keeps its idle cycle after pkt_last. Only the bench's scenarios can show which half-words survive, the exact packed content and padding, the per-link event-number adjustment including wrap-around at zero, the effect of turning off the bunch-crossing check, and the result of masking. A scoreboard model built from the requirements predicts these.

// File: rtl/evid_pkg.sv
package evid_pkg;
   localparam int ERRW = 10;
   localparam int E_HDR  = 0;
   localparam int E_TRL  = 1;
   localparam int E_FLAG = 2;
   localparam int E_SYNC = 3;
   localparam int E_HIT  = 4;
   localparam int E_L1   = 5;
   localparam int E_BC   = 6;
   localparam int E_TMO  = 7;
   localparam int E_AFUL = 8;
   localparam int E_OVF  = 9;

   typedef enum logic [2:0] {
      K_FLAG = 3'b000,
      K_HDR  = 3'b001,
      K_TRL  = 3'b010,
      K_RAW  = 3'b011,
      K_HIT  = 3'b100
   } kind_e;

   function automatic kind_e pkt_kind(input logic [15:0] d);
      if (d[15]) return K_HIT;
      return kind_e'(d[15:13]);
   endfunction
endpackage

// File: rtl/evid_pkt_decode.sv
module evid_pkt_decode
   import evid_pkg::*;
#(
   parameter int NLINK = 12,
   parameter int L1W   = 24,
   parameter int LINKW = 4
) (
   input  logic [L1W-1:0]     evt_l1id,
   input  logic [7:0]         evt_bcid,
   input  logic [2*NLINK-1:0] dyn_mask,
   input  logic               bcid_chk_en,
   input  logic [15:0]        pkt_data,
   input  logic [LINKW-1:0]   pkt_link,
   input  logic               pkt_cond,
   input  logic               pkt_tmo,
   output kind_e              kind,
   output logic [ERRW-1:0]    err
);
   localparam int NSLOT = 1 << LINKW;

   logic [3:0] exp_nib [NSLOT];

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      if (g < NLINK) begin : g_adj
         logic [L1W-1:0] adj;
         always_comb begin
            unique case (dyn_mask[2*g +: 2])
               2'b01:   adj = evt_l1id + L1W'(1);
               2'b10:   adj = evt_l1id - L1W'(1);
               default: adj = evt_l1id;
            endcase
            exp_nib[g] = adj[3:0];
         end
      end else begin : g_pad
         assign exp_nib[g] = evt_l1id[3:0];
      end
   end

   logic [3:0] sel_nib;
   assign sel_nib = exp_nib[pkt_link];

   always_comb begin
      kind = pkt_kind(pkt_data);
      err  = '0;
      unique case (kind)
         K_HDR: begin
            err[E_HDR] = pkt_data[12];
            err[E_L1]  = (pkt_data[11:8] != sel_nib);
            err[E_BC]  = bcid_chk_en && (pkt_data[7:0] != evt_bcid);
         end
         K_TRL: begin
            err[E_TRL]  = pkt_data[12];
            err[E_AFUL] = pkt_data[11];
            err[E_OVF]  = pkt_data[10];
         end
         K_FLAG:  err[E_FLAG] = 1'b1;
         K_RAW:   err[E_SYNC] = 1'b1;
         default: err[E_HIT]  = pkt_cond && (pkt_data[2] || pkt_data[3]);
      endcase
      err[E_TMO] = pkt_tmo;
   end
endmodule

// File: rtl/evid_err_tally.sv
module evid_err_tally
   import evid_pkg::*;
#(
   parameter int NLINK = 12,
   parameter int LINKW = 4,
   parameter int CNTW  = 8,
   parameter int GCNTW = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_en,
   input  logic [LINKW-1:0]      acc_link,
   input  logic [ERRW-1:0]       acc_err,
   input  logic                  close,
   input  logic [ERRW*NLINK-1:0] err_mask,
   output logic [CNTW*NLINK-1:0] link_cnt,
   output logic [GCNTW-1:0]      glob_cnt,
   output logic [ERRW-1:0]       summary
);
   logic [ERRW-1:0]  masked [NLINK];
   logic [NLINK-1:0] hit;

   for (genvar g = 0; g < NLINK; g++) begin : g_link
      logic [ERRW-1:0] pend;
      logic [CNTW-1:0] cnt;

      assign masked[g] = pend & err_mask[g*ERRW +: ERRW];
      assign hit[g]    = |masked[g];
      assign link_cnt[g*CNTW +: CNTW] = cnt;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            pend <= '0;
            cnt  <= '0;
         end else if (close) begin
            pend <= '0;
            if (hit[g]) cnt <= cnt + CNTW'(1);
         end else if (acc_en && acc_link == LINKW'(g)) begin
            pend <= pend | acc_err;
         end
      end
   end

   logic [ERRW-1:0] or_all;
   always_comb begin
      or_all = '0;
      for (int i = 0; i < NLINK; i++) or_all |= masked[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         glob_cnt <= '0;
         summary  <= '0;
      end else if (close) begin
         glob_cnt <= glob_cnt + GCNTW'($countones(hit));
         summary  <= or_all;
      end
   end
endmodule

// File: rtl/evid_half_packer.sv
module evid_half_packer #(
   parameter int WCW = 12
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           a_vld,
   input  logic [15:0]    a_hw,
   input  logic           b_vld,
   input  logic [15:0]    b_hw,
   input  logic           flush,
   output logic           out_vld,
   output logic [31:0]    out_word,
   output logic           done,
   output logic [WCW-1:0] word_count
);
   logic           pend_v;
   logic [15:0]    pend_hw;
   logic [WCW-1:0] wc;
   logic [15:0]    h0;
   logic           two, any;

   assign h0  = a_vld ? a_hw : b_hw;
   assign two = a_vld && b_vld;
   assign any = a_vld || b_vld;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_v     <= 1'b0;
         pend_hw    <= '0;
         wc         <= '0;
         out_vld    <= 1'b0;
         out_word   <= '0;
         done       <= 1'b0;
         word_count <= '0;
      end else begin
         out_vld <= 1'b0;
         done    <= 1'b0;
         if (flush) begin
            done <= 1'b1;
            wc   <= '0;
            if (pend_v) begin
               out_vld    <= 1'b1;
               out_word   <= {16'h0000, pend_hw};
               pend_v     <= 1'b0;
               word_count <= wc + WCW'(1);
            end else begin
               word_count <= wc;
            end
         end else if (any) begin
            if (pend_v) begin
               out_vld  <= 1'b1;
               out_word <= {h0, pend_hw};
               wc       <= wc + WCW'(1);
               pend_v   <= two;
               pend_hw  <= b_hw;
            end else if (two) begin
               out_vld  <= 1'b1;
               out_word <= {b_hw, a_hw};
               wc       <= wc + WCW'(1);
            end else begin
               pend_v  <= 1'b1;
               pend_hw <= h0;
            end
         end
      end
   end
endmodule

// File: rtl/evid_pack_engine.sv
module evid_pack_engine
   import evid_pkg::*;
#(
   parameter int NLINK = 12,
   parameter int L1W   = 24,
   parameter int CNTW  = 8,
   parameter int GCNTW = 16,
   parameter int WCW   = 12,
   localparam int LINKW = (NLINK > 1) ? $clog2(NLINK) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bcid_chk_en,
   input  logic [L1W-1:0]        evt_l1id,
   input  logic [7:0]            evt_bcid,
   input  logic [2*NLINK-1:0]    dyn_mask,
   input  logic [10*NLINK-1:0]   err_mask,
   input  logic                  pkt_valid,
   input  logic                  pkt_last,
   input  logic [LINKW-1:0]      pkt_link,
   input  logic                  pkt_cond,
   input  logic                  pkt_tmo,
   input  logic [15:0]           pkt_data,
   output logic                  out_valid,
   output logic [31:0]           out_word,
   output logic                  evt_done,
   output logic [WCW-1:0]        evt_word_count,
   output logic [9:0]            evt_err_summary,
   output logic [CNTW*NLINK-1:0] link_err_count,
   output logic [GCNTW-1:0]      global_err_count
);
   if (NLINK < 2)  begin : g_bad_nlink $error("NLINK must be at least 2"); end
   if (L1W < 4)    begin : g_bad_l1w   $error("L1W must be at least 4"); end
   if (CNTW < 1 || GCNTW < 1 || WCW < 2) begin : g_bad_cnt $error("counter widths too small"); end

   kind_e           kind;
   logic [ERRW-1:0] perr;

   evid_pkt_decode #(.NLINK(NLINK), .L1W(L1W), .LINKW(LINKW)) u_dec (
      .evt_l1id(evt_l1id), .evt_bcid(evt_bcid), .dyn_mask(dyn_mask),
      .bcid_chk_en(bcid_chk_en), .pkt_data(pkt_data), .pkt_link(pkt_link),
      .pkt_cond(pkt_cond), .pkt_tmo(pkt_tmo), .kind(kind), .err(perr)
   );

   // header hold stage
   logic             hold_v, hold_e, flush_q;
   logic [15:0]      hold_d;
   logic [LINKW-1:0] hold_l;
   logic             trl_clean, drop_hdr, a_vld, b_vld;

   assign trl_clean = (kind == K_TRL) && !(pkt_data[12] || pkt_data[11] || pkt_data[10]) && !pkt_tmo;
   assign drop_hdr  = hold_v && pkt_valid && trl_clean && (pkt_link == hold_l) && !hold_e;
   assign a_vld     = hold_v && pkt_valid && !drop_hdr;

   always_comb begin
      unique case (kind)
         K_HDR:   b_vld = pkt_valid && pkt_last;
         K_TRL:   b_vld = pkt_valid && (pkt_data[12] || pkt_data[11]);
         default: b_vld = pkt_valid;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_v  <= 1'b0;
         hold_e  <= 1'b0;
         hold_d  <= '0;
         hold_l  <= '0;
         flush_q <= 1'b0;
      end else begin
         flush_q <= pkt_valid && pkt_last;
         if (pkt_valid) begin
            hold_v <= (kind == K_HDR) && !pkt_last;
            hold_e <= |perr;
            hold_d <= pkt_data;
            hold_l <= pkt_link;
         end
      end
   end

   evid_err_tally #(.NLINK(NLINK), .LINKW(LINKW), .CNTW(CNTW), .GCNTW(GCNTW)) u_tally (
      .clk(clk), .rst_n(rst_n), .acc_en(pkt_valid), .acc_link(pkt_link),
      .acc_err(perr), .close(flush_q), .err_mask(err_mask),
      .link_cnt(link_err_count), .glob_cnt(global_err_count),
      .summary(evt_err_summary)
   );

   evid_half_packer #(.WCW(WCW)) u_pack (
      .clk(clk), .rst_n(rst_n), .a_vld(a_vld), .a_hw(hold_d),
      .b_vld(b_vld), .b_hw(pkt_data), .flush(flush_q),
      .out_vld(out_valid), .out_word(out_word), .done(evt_done),
      .word_count(evt_word_count)
   );
endmodule

// File: rtl/evid_pack_chk.sv
module evid_pack_chk #(
   parameter int NLINK = 12,
   parameter int CNTW  = 8,
   parameter int GCNTW = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  pkt_valid,
   input logic                  pkt_last,
   input logic                  out_valid,
   input logic                  evt_done,
   input logic [9:0]            evt_err_summary,
   input logic [CNTW*NLINK-1:0] link_err_count,
   input logic [GCNTW-1:0]      global_err_count
);
   p_idle_after_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid && pkt_last |=> !pkt_valid);

   p_done_timing_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_valid && pkt_last |-> ##2 evt_done);

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_done |=> !evt_done);

   p_glob_moves_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(global_err_count) |-> evt_done);

   p_link_moves_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(link_err_count) |-> evt_done);

   p_summary_moves_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(evt_err_summary) |-> evt_done);

   p_zero_summary_no_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
      evt_done && evt_err_summary == 10'd0 |-> $stable(global_err_count));

   p_word_has_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(pkt_valid) || $past(pkt_valid && pkt_last, 2));
endmodule

bind evid_pack_engine evid_pack_chk #(.NLINK(NLINK), .CNTW(CNTW), .GCNTW(GCNTW)) u_chk (
   .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_last(pkt_last),
   .out_valid(out_valid), .evt_done(evt_done), .evt_err_summary(evt_err_summary),
   .link_err_count(link_err_count), .global_err_count(global_err_count)
);

// File: tb/tb_evid_pack_engine.sv
module tb_evid_pack_engine;
   localparam int NL = 12;
   localparam int CW = 8;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic            rst_n;
   logic            bcid_chk_en;
   logic [23:0]     evt_l1id;
   logic [7:0]      evt_bcid;
   logic [2*NL-1:0] dyn_mask;
   logic [10*NL-1:0] err_mask;
   logic            pkt_valid, pkt_last, pkt_cond, pkt_tmo;
   logic [3:0]      pkt_link;
   logic [15:0]     pkt_data;
   logic            out_valid, evt_done;
   logic [31:0]     out_word;
   logic [11:0]     evt_word_count;
   logic [9:0]      evt_err_summary;
   logic [CW*NL-1:0] link_err_count;
   logic [15:0]     global_err_count;

   evid_pack_engine dut (
      .clk(clk), .rst_n(rst_n), .bcid_chk_en(bcid_chk_en), .evt_l1id(evt_l1id),
      .evt_bcid(evt_bcid), .dyn_mask(dyn_mask), .err_mask(err_mask),
      .pkt_valid(pkt_valid), .pkt_last(pkt_last), .pkt_link(pkt_link),
      .pkt_cond(pkt_cond), .pkt_tmo(pkt_tmo), .pkt_data(pkt_data),
      .out_valid(out_valid), .out_word(out_word), .evt_done(evt_done),
      .evt_word_count(evt_word_count), .evt_err_summary(evt_err_summary),
      .link_err_count(link_err_count), .global_err_count(global_err_count)
   );

   typedef struct packed {
      logic        tmo;
      logic        cond;
      logic [3:0]  link;
      logic [15:0] d;
   } pkt_t;

   typedef struct packed {
      logic [11:0]      wc;
      logic [9:0]       summ;
      logic [15:0]      gc;
      logic [CW*NL-1:0] lc;
   } done_t;

   pkt_t        evq[$];
   logic [31:0] exp_words[$];
   done_t       exp_done[$];
   int          exp_lc[NL];
   int          exp_gc;
   int          n_chk, n_fail;

   task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   // packet builders
   task automatic add(input logic [3:0] l, input logic [15:0] d, input bit c = 0, input bit t = 0);
      pkt_t p;
      p.tmo = t; p.cond = c; p.link = l; p.d = d;
      evq.push_back(p);
   endtask
   function automatic logic [15:0] hdr(input bit perr, input logic [3:0] l1, input logic [7:0] bc);
      return {3'b001, perr, l1, bc};
   endfunction
   function automatic logic [15:0] trl(input bit z, input bit h, input bit v);
      return {3'b010, z, h, v, 10'h000};
   endfunction

   // expected error vector from the requirement text (R1, R2, R3)
   function automatic logic [9:0] m_err(input pkt_t p);
      logic [9:0]  e;
      logic [23:0] x;
      e = '0;
      unique case (dyn_mask[2*p.link +: 2])
         2'b01:   x = evt_l1id + 24'd1;
         2'b10:   x = evt_l1id - 24'd1;
         default: x = evt_l1id;
      endcase
      if (p.d[15]) e[4] = p.cond && (p.d[2] || p.d[3]);
      else case (p.d[15:13])
         3'b001: begin
            e[0] = p.d[12];
            e[5] = p.d[11:8] != x[3:0];
            e[6] = bcid_chk_en && p.d[7:0] != evt_bcid;
         end
         3'b010: begin e[1] = p.d[12]; e[8] = p.d[11]; e[9] = p.d[10]; end
         3'b000: e[2] = 1'b1;
         default: e[3] = 1'b1;
      endcase
      e[7] = p.tmo;
      return e;
   endfunction

   // scoreboard driver: model then drive one event
   task automatic run_event();
      logic [15:0] hw[$];
      logic [9:0]  lerr[NL];
      logic [9:0]  summ, mk;
      bit          hv, he;
      logic [15:0] hd;
      logic [3:0]  hl;
      done_t       dn;
      int          n;
      for (int k = 0; k < NL; k++) lerr[k] = '0;
      hv = 0; he = 0; hd = '0; hl = '0;
      for (int i = 0; i < evq.size(); i++) begin
         pkt_t p;
         logic [9:0] e;
         bit last, is_t, clean;
         p = evq[i];
         last = (i == evq.size() - 1);
         e = m_err(p);
         lerr[p.link] |= e;
         is_t  = !p.d[15] && p.d[15:13] == 3'b010;
         clean = is_t && !p.d[12] && !p.d[11] && !p.d[10] && !p.tmo;
         if (hv) begin
            if (!(clean && p.link == hl && !he)) hw.push_back(hd);
            hv = 0;
         end
         if (!p.d[15] && p.d[15:13] == 3'b001) begin
            if (last) hw.push_back(p.d);
            else begin hv = 1; hd = p.d; hl = p.link; he = |e; end
         end else if (is_t) begin
            if (p.d[12] || p.d[11]) hw.push_back(p.d);
         end else hw.push_back(p.d);
      end
      n = hw.size();
      for (int i = 0; i < n; i += 2)
         exp_words.push_back({(i + 1 < n) ? hw[i+1] : 16'h0000, hw[i]});
      summ = '0;
      for (int k = 0; k < NL; k++) begin
         mk = lerr[k] & err_mask[10*k +: 10];
         if (mk != 0) begin exp_lc[k]++; exp_gc++; summ |= mk; end
      end
      dn.wc = 12'((n + 1) / 2);
      dn.summ = summ;
      dn.gc = 16'(exp_gc);
      for (int k = 0; k < NL; k++) dn.lc[CW*k +: CW] = CW'(exp_lc[k]);
      exp_done.push_back(dn);
      for (int i = 0; i < evq.size(); i++) begin
         @(posedge clk); #1;
         pkt_valid = 1'b1;
         pkt_last  = (i == evq.size() - 1);
         pkt_link  = evq[i].link;
         pkt_cond  = evq[i].cond;
         pkt_tmo   = evq[i].tmo;
         pkt_data  = evq[i].d;
      end
      @(posedge clk); #1;
      pkt_valid = 1'b0; pkt_last = 1'b0; pkt_tmo = 1'b0; pkt_cond = 1'b0;
      repeat (4) @(posedge clk);
      evq.delete();
   endtask

   // monitor
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_words.size() == 0) chk(0, "R7 unexpected word", out_word, 0);
         else begin
            logic [31:0] w;
            w = exp_words.pop_front();
            chk(out_word == w, "R5 R6 R7 R8 word", out_word, w);
         end
      end
      if (rst_n && evt_done) begin
         if (exp_done.size() == 0) chk(0, "R9 unexpected done", 0, 0);
         else begin
            done_t d;
            d = exp_done.pop_front();
            chk(evt_word_count == d.wc, "R9 word count", evt_word_count, d.wc);
            chk(evt_err_summary == d.summ, "R4 summary", evt_err_summary, d.summ);
            chk(global_err_count == d.gc, "R4 global count", global_err_count, d.gc);
            chk(link_err_count == d.lc, "R4 link counts", link_err_count, d.lc);
         end
      end
   end

   bit finished = 0;
   task automatic finish_up();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_up();
   end

   initial begin
      n_chk = 0; n_fail = 0; exp_gc = 0;
      for (int k = 0; k < NL; k++) exp_lc[k] = 0;
      rst_n = 1'b0; bcid_chk_en = 1'b1; evt_l1id = 24'h000123; evt_bcid = 8'h45;
      dyn_mask = '0; err_mask = {NL{10'h3FF}};
      pkt_valid = 0; pkt_last = 0; pkt_link = 0; pkt_cond = 0; pkt_tmo = 0; pkt_data = 0;
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(out_valid == 0, "R10 out_valid", out_valid, 0);
      chk(evt_done == 0, "R10 evt_done", evt_done, 0);
      chk(global_err_count == 0, "R10 global", global_err_count, 0);
      chk(link_err_count == 0, "R10 link counts", link_err_count, 0);
      chk(evt_err_summary == 0, "R10 summary", evt_err_summary, 0);

      // E1: R5 R6 R7 R8 - clean pairs dropped, almost-full trailer kept, odd pad
      add(0, hdr(0, 4'h3, 8'h45)); add(0, 16'h8810, 1); add(0, 16'h8821, 1); add(0, trl(0,0,0));
      add(1, hdr(0, 4'h3, 8'h45)); add(1, trl(0,0,0));
      add(2, hdr(0, 4'h3, 8'h45)); add(2, trl(0,1,0));
      run_event();

      // E2: R1 per-link adjust (01, 10 mismatch, 11 plain), R2 BCID mismatch
      dyn_mask[2*3 +: 2] = 2'b01; dyn_mask[2*4 +: 2] = 2'b10; dyn_mask[2*6 +: 2] = 2'b11;
      add(3, hdr(0, 4'h4, 8'h45)); add(3, trl(0,0,0));
      add(4, hdr(0, 4'h3, 8'h45)); add(4, trl(0,0,0));
      add(5, hdr(0, 4'h3, 8'h46)); add(5, trl(0,0,0));
      add(6, hdr(0, 4'h3, 8'h45)); add(6, trl(0,0,0));
      run_event();

      // E3: R2 BCID check off; R3 raw packet sets sync bit
      bcid_chk_en = 1'b0; dyn_mask = '0;
      add(5, hdr(0, 4'h3, 8'h99)); add(5, trl(0,0,0));
      add(0, hdr(0, 4'h3, 8'h45)); add(0, 16'h6123); add(0, trl(0,0,0));
      run_event();

      // E4: R1 wrap at zero, expanded hit bits ignored (R3), even count no pad (R8)
      bcid_chk_en = 1'b1; evt_l1id = 24'h000000; evt_bcid = 8'h10;
      dyn_mask[2*7 +: 2] = 2'b10; dyn_mask[2*8 +: 2] = 2'b01;
      add(7, hdr(0, 4'hF, 8'h10)); add(7, trl(0,0,0));
      add(8, hdr(0, 4'h1, 8'h10)); add(8, 16'h800C, 0); add(8, trl(0,0,0));
      run_event();

      // E5: R3 flagged, header bit, timeout, trailer error, condensed hit error; R4 masks
      dyn_mask = '0;
      err_mask[10*9 +: 10] = 10'h000; err_mask[10*10 +: 10] = 10'h081;
      add(9, 16'h0005);
      add(10, hdr(1, 4'h0, 8'h10), 0, 1); add(10, trl(0,0,0));
      add(11, trl(1,0,0));
      add(0, hdr(0, 4'h0, 8'h10)); add(0, 16'h8004, 1); add(0, trl(0,0,1));
      run_event();

      // E6: R6 R8 header arriving as last packet is written and padded
      err_mask = {NL{10'h3FF}};
      add(0, hdr(0, 4'h0, 8'h10));
      run_event();

      repeat (6) @(posedge clk);
      chk(exp_words.size() == 0, "R7 words left", exp_words.size(), 0);
      chk(exp_done.size() == 0, "R9 events left", exp_done.size(), 0);
      finish_up();
   end
endmodule